// File: doc/BRIEF.md
# Post-Increment Store Unit

This unit executes integer store operations that use post-increment addressing. For each accepted operation it issues one memory write at the base register's current value. It also computes the new base value, which is the base plus either a displacement or an index register, and returns it for writeback to the base register.

The caller presents a decoded operation and the three register operands with a valid/ready handshake. The unit holds that operation as a write request on a 64-bit little-endian memory write port. The data is placed in the right byte lanes and carries byte enables. The base writeback is released in the same cycle the memory port takes the write, so a stalled store never updates the base early. No status or special register is touched.

Top module: `poststore_unit`

## Requirements
- R1: The memory write address `mem_addr` equals the base operand as it was when the operation was accepted, never the incremented value.
- R2: For the immediate form (`op_indexed`=0) with `op_size` 0, 1 or 2, the new base is the base plus the 16-bit `op_disp` sign-extended to 64 bits.
- R3: For the immediate form with `op_size`=3, the two low bits of `op_disp` are treated as zero before sign extension, so the offset is a multiple of 4.
- R4: For the indexed form (`op_indexed`=1) the new base is the base plus `index_val`, and `op_disp` has no effect.
- R5: Address arithmetic wraps modulo 2^64.
- R6: `op_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. `mem_be` bit k is set exactly when k is at least the low three address bits (the lane) and k is below lane plus the size. Lanes past bit 7 are dropped.
- R7: `mem_data` byte k holds source byte (k - lane) when `mem_be` bit k is set, and zero otherwise. Only the low 1, 2 or 4 bytes of the source reach memory for the smaller sizes, and all 8 bytes for size 3.
- R8: `op_ready` is high only while no write is pending. An accepted operation raises `mem_valid` on the next cycle. While `mem_valid` is high and `mem_ready` is low, the request holds stable and any new operation offered is ignored.
- R9: `wb_valid` is high exactly in a cycle where `mem_valid` and `mem_ready` are both high, with `wb_data` holding the new base. Each operation gives one write and one writeback, after which `mem_valid` falls.
- R10: After reset `mem_valid` and `wb_valid` are low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_size | input | 2 | Access size code (0..3 = 1,2,4,8 bytes) |
| op_indexed | input | 1 | 1 = offset from index register, 0 = from displacement |
| op_disp | input | 16 | Displacement field |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| src_val | input | 64 | Value to store |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory port takes the write |
| mem_addr | output | 64 | Write address (old base) |
| mem_data | output | 64 | Lane-aligned write data |
| mem_be | output | 8 | Byte enables |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_data | output | 64 | New base value |

## Verification
An operation taken at a rising edge shows on the write port from that edge on, so the bench drives on falling edges and checks the address, enables, data and `op_ready` at the very next falling edge. The writeback is combinational on the handshake. It is therefore checked at the falling edge where `mem_ready` was raised, before the edge that completes the write. One falling edge later the bench checks that `mem_valid` has dropped and `op_ready` has returned. During stalls of zero to two cycles it checks at every falling edge that the request is unchanged and that no writeback has appeared.

// File: rtl/poststore_unit.sv
module poststore_unit #(
  parameter int XLEN  = 64,
  parameter int DISPW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_indexed,
  input  logic [DISPW-1:0]  op_disp,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [XLEN-1:0]   src_val,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_data,
  output logic [XLEN/8-1:0] mem_be,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_data
);
  localparam int LANES = XLEN / 8;
  localparam int OFFW  = $clog2(LANES);

  logic              busy;
  logic [XLEN-1:0]   addr_q, data_q, nb_q;
  logic [LANES-1:0]  be_q;

  logic [DISPW-1:0]  disp_eff;
  logic [XLEN-1:0]   offset, new_base, src_kept, data_sh;
  logic [LANES-1:0]  size_mask, be_sh;
  logic [OFFW-1:0]   lane;

  assign disp_eff = (op_size == 2'd3 && !op_indexed) ? {op_disp[DISPW-1:2], 2'b00} : op_disp;
  assign offset   = op_indexed ? index_val : {{(XLEN-DISPW){disp_eff[DISPW-1]}}, disp_eff};
  assign new_base = base_val + offset;
  assign lane     = base_val[OFFW-1:0];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      size_mask[i] = (i < (1 << op_size));
      src_kept[8*i +: 8] = size_mask[i] ? src_val[8*i +: 8] : 8'h00;
    end
  end

  assign be_sh   = size_mask << lane;
  assign data_sh = src_kept << {lane, 3'b000};

  wire accept = op_valid && op_ready;
  wire done   = busy && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= base_val;
      data_q <= data_sh;
      be_q   <= be_sh;
      nb_q   <= new_base;
    end
  end

  assign op_ready  = !busy;
  assign mem_valid = busy;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign mem_be    = be_q;
  assign wb_valid  = done;
  assign wb_data   = nb_q;
endmodule

module poststore_unit_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_data,
  input logic [XLEN/8-1:0] mem_be,
  input logic              wb_valid,
  input logic [XLEN-1:0]   wb_data
);
  AST_ACCEPT_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_ready) |=> mem_valid); // R8
  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> !op_ready); // R8
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be) && $stable(wb_data))); // R8
  AST_WB_ONLY_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) wb_valid |-> (mem_valid && mem_ready)); // R9
  AST_HANDSHAKE_GIVES_WB: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_ready) |-> wb_valid); // R9
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_ready) |=> !mem_valid); // R9
  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> (mem_be != '0)); // R6
endmodule

bind poststore_unit poststore_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_be(mem_be), .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/poststore_unit_bench.sv
module poststore_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_indexed = 1'b0;
  logic [15:0] op_disp = '0;
  logic [63:0] base_val = '0, index_val = '0, src_val = '0;
  logic        mem_valid, mem_ready = 1'b0;
  logic [63:0] mem_addr, mem_data, wb_data;
  logic [7:0]  mem_be;
  logic        wb_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  poststore_unit u_poststore_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_indexed(op_indexed), .op_disp(op_disp),
    .base_val(base_val), .index_val(index_val), .src_val(src_val),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .wb_valid(wb_valid), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input bit idx, input logic [15:0] disp,
                        input logic [63:0] base, input logic [63:0] index,
                        input logic [63:0] src, input int stall, input string rq);
    logic [63:0] off, nb, ed;
    logic [7:0]  eb;
    int lane, nbytes;
    lane = int'(base[2:0]);
    nbytes = 1 << sz;
    if (idx) off = index;
    else if (sz == 2'd3) off = {{48{disp[15]}}, disp & 16'hFFFC};
    else off = {{48{disp[15]}}, disp};
    nb = base + off;
    eb = '0;
    ed = '0;
    for (int k = 0; k < 8; k++) begin
      if (k >= lane && k < lane + nbytes) begin
        eb[k] = 1'b1;
        ed[8*k +: 8] = src[8*(k-lane) +: 8];
      end
    end
    @(negedge clk);
    op_size = sz; op_indexed = idx; op_disp = disp;
    base_val = base; index_val = index; src_val = src;
    op_valid = 1'b1; mem_ready = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    chk(mem_valid === 1'b1, "R8 valid after accept", {63'b0, mem_valid}, 64'd1);
    chk(op_ready === 1'b0, "R8 not ready when busy", {63'b0, op_ready}, 64'd0);
    chk(mem_addr === base, "R1 address is old base", mem_addr, base);
    chk(mem_be === eb, "R6 byte enables", {56'b0, mem_be}, {56'b0, eb});
    chk(mem_data === ed, "R7 lane data", mem_data, ed);
    chk(wb_valid === 1'b0, "R9 no wb before handshake", {63'b0, wb_valid}, 64'd0);
    for (int s = 0; s < stall; s++) begin
      op_valid = (s == 0);
      base_val = ~base; op_size = ~sz; src_val = ~src;
      @(negedge clk);
      chk(mem_valid === 1'b1 && mem_addr === base, "R8 stalled request held", mem_addr, base);
      chk(wb_valid === 1'b0, "R9 no wb while stalled", {63'b0, wb_valid}, 64'd0);
    end
    op_valid = 1'b0;
    mem_ready = 1'b1;
    #1;
    chk(wb_valid === 1'b1, "R9 wb on handshake", {63'b0, wb_valid}, 64'd1);
    chk(wb_data === nb, rq, wb_data, nb);
    chk(mem_addr === base && mem_data === ed, "R8 offered op ignored", mem_addr, base);
    @(negedge clk);
    mem_ready = 1'b0;
    chk(mem_valid === 1'b0 && wb_valid === 1'b0, "R9 single write", {62'b0, mem_valid, wb_valid}, 64'd0);
    chk(op_ready === 1'b1, "R8 ready after write", {63'b0, op_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_valid === 1'b0 && wb_valid === 1'b0, "R10 reset outputs low", {62'b0, mem_valid, wb_valid}, 64'd0);
    chk(op_ready === 1'b1, "R10 ready in reset", {63'b0, op_ready}, 64'd1);
    rst_n = 1'b1;
    for (int sz = 0; sz < 4; sz++)
      for (int ln = 0; ln < 8; ln++)
        for (int ix = 0; ix < 2; ix++) begin
          logic [63:0] b;
          logic [15:0] d;
          b = 64'h0123_4567_89AB_CD00 + 64'(sz * 64 + ln);
          d = (ln[0]) ? 16'h8003 + 16'(ln * 16) : 16'h0007 + 16'(ln * 256);
          run_op(2'(sz), ix[0], d, b, 64'hFFFF_FFFF_FFFF_FF00 + 64'(ln),
                 64'hF1E2_D3C4_B5A6_9788 ^ 64'(ln * 3 + sz), (sz + ln) % 3,
                 ix[0] ? "R4 indexed new base" : (sz == 3 ? "R3 aligned disp new base" : "R2 disp new base"));
        end
    run_op(2'd3, 1'b0, 16'h7FFF, 64'h0000_0000_0000_0010, 64'd0, 64'hAAAA_5555_AAAA_5555, 1, "R3 disp low bits dropped");
    run_op(2'd3, 1'b0, 16'hFFFF, 64'h0000_0000_0000_0000, 64'd0, 64'h1, 0, "R5 wrap below zero");
    run_op(2'd2, 1'b1, 16'h1234, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 64'hDEAD_BEEF_CAFE_F00D, 2, "R5 wrap indexed");
    run_op(2'd0, 1'b0, 16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h5A, 0, "R5 wrap positive disp");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule